// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block turns a fast reference clock into the sampling tick a serial channel needs. The tick runs at sixteen times the line bit rate, which suits a receiver that oversamples each bit sixteen times. Software writes one 32-bit control word. The word holds a run flag, a select for an optional fixed divide-by-16 stage in front of the main counter, and a 12-bit reload value. The reload value is the wanted ratio minus one. It sits one bit up from the bottom of the word, so the word is the ratio minus one, shifted left by one.

A reloadable down-counter emits a tick that is one reference cycle wide each time it passes through zero. The block also brings out a squarer divided clock, which is high while the counter sits in the upper half of its range. A chip carries several copies of the block. Routing the outputs to the channels is done outside it. Every write of the control word restarts both the prescale stage and the counter, so the tick phase after a write is known.

Top module: `rate_tick_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), cfg_rdata reads 0 and both tick_o and div_clk_o are low.
- R2: The control word has three fields. Bit 16 is the run flag. Bit 14 selects the divide-by-16 prescale stage. Bits 12:1 hold the reload value D. Every other bit is dropped on write and reads back as 0, so cfg_rdata equals the last written word ANDed with 0x00015FFE.
- R3: While the run flag is 0, tick_o stays low, div_clk_o stays low and the counter holds its value.
- R4: With the run flag set and prescale off, tick_o is high for exactly one cycle in every D+1 cycles. The single exception is D = 0, where tick_o stays high continuously.
- R5: With the run flag set and prescale on, the tick period is 16·(D+1) cycles.
- R6: A write restarts the timing. The first tick is high in the cycle that begins ratio−1 rising edges after the write edge, where ratio is (D+1) or 16·(D+1). This holds whatever the phase was before the write.
- R7: Over each tick period, div_clk_o is high for (D − floor(D/2)) counter steps, where a step is one cycle without prescale and 16 cycles with it. An even ratio therefore gives exactly half the period high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Control word read back, undefined bits zero |
| tick_o | output | 1 | One-cycle baud tick enable |
| div_clk_o | output | 1 | Divided clock, roughly 50% duty |

## Verification
Suppose the counter or the prescale stage held a wrong value. The port would then show a tick in the wrong cycle, either after the first write or one period later. The bench measures the exact cycle of the first tick and the spacing to the second, so such a fault shows within two periods. A wrong compare threshold changes the number of high div_clk_o samples counted over one period. A decode error appears at once in cfg_rdata, and the bench also sees it as a wrong period.

// File: rtl/rate_gen_pkg.sv
// Shared field layout and configuration type for the baud tick generator.
package rate_gen_pkg;
    localparam int REG_W     = 32;
    localparam int DIV_W     = 12;
    localparam int DIV_LSB   = 1;
    localparam int PRE_BIT   = 14;
    localparam int RUN_BIT   = 16;
    localparam int PRE_RATIO = 16;

    typedef struct packed {
        logic             run;
        logic             pre;
        logic [DIV_W-1:0] div;
    } rate_cfg_t;

    localparam logic [REG_W-1:0] FIELD_MASK =
        (REG_W'(1) << RUN_BIT) | (REG_W'(1) << PRE_BIT) |
        (((REG_W'(1) << DIV_W) - REG_W'(1)) << DIV_LSB);
endpackage

// File: rtl/rate_cfg_reg.sv
// Control word register: decodes a write into fields and assembles readback.
// Assumes one write per strobe cycle; undefined bits are discarded.
module rate_cfg_reg
    import rate_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output rate_cfg_t        cfg_q,
    output rate_cfg_t        cfg_d,
    output logic [REG_W-1:0] rd_data
);
    logic unused_bits;

    // Decode incoming write data into fields.
    always_comb begin
        cfg_d.run = wr_data[RUN_BIT];
        cfg_d.pre = wr_data[PRE_BIT];
        cfg_d.div = wr_data[DIV_LSB +: DIV_W];
    end

    assign unused_bits = ^(wr_data & ~FIELD_MASK);

    // Hold the configuration; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= cfg_d;
    end

    // Place fields back at their bit positions; all others zero.
    always_comb begin
        rd_data                    = '0;
        rd_data[RUN_BIT]           = cfg_q.run;
        rd_data[PRE_BIT]           = cfg_q.pre;
        rd_data[DIV_LSB +: DIV_W]  = cfg_q.div;
    end
endmodule

// File: rtl/rate_prescale.sv
// Optional fixed prescaler: produces a step strobe every cycle when bypassed,
// or once per RATIO cycles when selected. Restart clears its phase.
module rate_prescale #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic pre_sel,
    output logic step
);
    localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    logic [PW-1:0] pc;

    // Phase counter, advancing only while prescale is in use.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            pc <= '0;
        else if (run && pre_sel)
            pc <= (pc == LAST) ? '0 : pc + 1'b1;
    end

    // Step strobe: every cycle when bypassed, at the last phase otherwise.
    generate
        if (RATIO > 1) begin : g_pre
            assign step = run && (!pre_sel || (pc == LAST));
        end else begin : g_nopre
            assign step = run;
        end
    endgenerate

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pc == '0)); // R6
    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc == LAST && run && pre_sel && !restart) |=> (pc == '0)); // R5
endmodule

// File: rtl/rate_down_counter.sv
// Reloadable down-counter: loads on restart, decrements on each step,
// reloads and ticks on a step at zero. Also forms the divided clock.
module rate_down_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             tick,
    output logic             half_clk
);
    logic [CNT_W-1:0] cnt;

    // Counter: restart load, reload at zero, else decrement on step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= start_val;
        else if (step)
            cnt <= (cnt == '0) ? reload_val : cnt - 1'b1;
    end

    // Tick on the step that finds the counter at zero.
    assign tick = step && (cnt == '0);

    // Divided clock: high while the count is in the upper half.
    assign half_clk = run && (cnt > (reload_val >> 1));

    AST_LOAD_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == $past(start_val))); // R6
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == '0 && !restart) |=> (cnt == $past(reload_val))); // R4
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(cnt)); // R3
endmodule

// File: rtl/rate_tick_gen.sv
// Baud tick generator top: control word, optional prescaler and a
// reloadable down-counter. Any write restarts prescaler and counter.
// Assumes a synchronous active-low reset and a single clock domain.
module rate_tick_gen
    import rate_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             tick_o,
    output logic             div_clk_o
);
    rate_cfg_t cfg_q;
    rate_cfg_t cfg_d;
    logic      step;

    rate_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q),
        .cfg_d   (cfg_d),
        .rd_data (cfg_rdata)
    );

    rate_prescale #(.RATIO(PRE_RATIO)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_wr),
        .run     (cfg_q.run),
        .pre_sel (cfg_q.pre),
        .step    (step)
    );

    rate_down_counter #(.CNT_W(DIV_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cfg_wr),
        .run        (cfg_q.run),
        .step       (step),
        .start_val  (cfg_d.div),
        .reload_val (cfg_q.div),
        .tick       (tick_o),
        .half_clk   (div_clk_o)
    );

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> cfg_q.run); // R3
    AST_DIVCLK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        div_clk_o |-> cfg_q.run); // R3
endmodule

// File: tb/sim_rate_tick_gen.sv
// Self-checking bench: vector table walked by one loop, then directed tests.
module sim_rate_tick_gen;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;
    localparam int NV         = 7;
    localparam logic [31:0] MASK = 32'h0001_5FFE;

    // Stimulus word, expected period, expected high samples of div_clk_o.
    localparam logic [31:0] VEC_W [NV] = '{
        32'h0001_0000, 32'h0001_0002, 32'h0001_0012, 32'h0001_4004,
        32'h0001_1FFE, 32'h8011_4001, 32'h0001_A00D };
    localparam int VEC_RATIO [NV] = '{1, 2, 10, 48, 4096, 16, 7};
    localparam int VEC_HIGH  [NV] = '{0, 1, 5, 16, 2048, 0, 3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tick_o;
    logic        div_clk_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rate_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tick_o(tick_o), .div_clk_o(div_clk_o));

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Write at a negedge; returns at the negedge right after the write edge.
    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Measure first tick offset, period and div_clk_o high count.
    task automatic measure(input int ratio, input int high, input string tag);
        int first = -1;
        int second = -1;
        int hi = 0;
        for (int j = 0; j < LIMIT && second < 0; j++) begin
            if (j > 0) @(negedge clk);
            if (first >= 0 && div_clk_o) hi++;
            if (tick_o) begin
                if (first < 0) first = j;
                else second = j;
            end
        end
        check({tag, " R6 first tick"}, first, ratio - 1);
        check({tag, " R4/R5 period"}, second - first, ratio);
        check({tag, " R7 high count"}, hi, high);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ticks;
        int highs;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rdata", cfg_rdata, 0);
        check("R1 tick", tick_o, 0);
        check("R1 divclk", div_clk_o, 0);

        // Vector table: R2 readback, R4/R5/R6/R7 timing
        for (int v = 0; v < NV; v++) begin
            write_cfg(VEC_W[v]);
            check("R2 readback", cfg_rdata, VEC_W[v] & MASK);
            measure(VEC_RATIO[v], VEC_HIGH[v], "vec");
        end

        // R3: run flag clear, nothing toggles
        write_cfg(32'h0000_0006);
        check("R2 readback idle", cfg_rdata, 32'h0000_0006);
        ticks = 0;
        highs = 0;
        for (int j = 0; j < 40; j++) begin
            if (tick_o) ticks++;
            if (div_clk_o) highs++;
            @(negedge clk);
        end
        check("R3 ticks while idle", ticks, 0);
        check("R3 divclk while idle", highs, 0);

        // R6: rewrite mid-period restarts phase
        write_cfg(32'h0001_0012);
        repeat (4) @(negedge clk);
        write_cfg(32'h0001_0012);
        measure(10, 5, "restart");

        // R1: reset while running
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 rdata after reset", cfg_rdata, 0);
        check("R1 tick after reset", tick_o, 0);
        check("R1 divclk after reset", div_clk_o, 0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule